// File: doc/BRIEF.md
# Configured Channel Scan Sequencer

This block runs a sixteen-channel acquisition front end. After reset it fetches one configuration byte per channel through a simple byte-read port from an external nonvolatile-memory controller. The byte for each channel sets three things: whether the channel is enabled, the channel's input range code, and whether the channel's pull-up is connected. When all sixteen bytes have arrived, the block drives the pull-up lines. It then starts a fixed-rate round-robin scan over the enabled channels only.

In each time slot the sequencer selects one channel on the analog multiplexer and presents that channel's range code. It then pulses a conversion request. When the result comes back within the slot, the block stores it in an internal FIFO, tagged with the channel number. When no result comes back within the slot, the block counts the slot as an overrun. A host reads a status word and pops results over a small parallel register bus. A host write to a control register restarts the whole sequence: the block reloads the configuration, empties the buffer and clears the error indications.

Top module: `chan_scan_seq`

## Requirements
- R1: After reset, and after every reload, `cfgRdReq` stays high while the block reads the configuration addresses 0 to 15 in ascending order. Each address is held until `cfgRdValid` returns its byte. No `convReq` is raised while loading.
- R2: Configuration byte layout: bit 0 is the enable flag, bits 2:1 are the range code and bit 3 is the pull-up select. Bits 7:4 have no effect. While a channel is being sampled, `muxSel` carries its number and `rangeCode` carries its range code.
- R3: After loading, `rangeGpio[i]` equals the pull-up bit of channel i. All lines are 0 during reset and during the first load.
- R4: The scan gives each enabled channel one slot of `SLOT_CYCLES` cycles. It visits the channels in ascending order, wraps around and starts at the lowest enabled channel. Disabled channels take no slot. `convReq` is a one-cycle pulse in the first cycle of a slot. Status bit 4 is high while scanning.
- R5: A `convValid` that arrives after the request and no later than the last cycle of the slot stores `{channel, convData}` in the FIFO. A `convValid` that arrives at any other time is ignored.
- R6: A slot that ends with its result still missing increments the overrun count in status bits 15:8. The count saturates at 255, and a result that arrives later is discarded.
- R7: Reading address 4 returns the oldest entry, with the channel in bits 19:16 and the data in bits 15:0, and removes it. Reading address 4 while the FIFO is empty returns 0 and changes nothing. Status bit 0 means empty.
- R8: The FIFO holds 256 entries and status bit 1 means full. A result that arrives while the FIFO is full is dropped and sets a sticky overflow flag in status bit 2.
- R9: When no channel is enabled, status bit 3 goes high and the scan does not start. No conversion request is raised in this state.
- R10: Writing the value 1 to address 8 empties the FIFO, clears the overflow flag and the overrun count, and restarts the configuration load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgRdReq | output | 1 | Configuration byte read request |
| cfgRdAddr | output | CFG_AW | Configuration byte address |
| cfgRdValid | input | 1 | Requested configuration byte is present |
| cfgRdData | input | 8 | Configuration byte |
| rangeGpio | output | 16 | Per-channel pull-up select lines |
| muxSel | output | 4 | Analog multiplexer channel select |
| rangeCode | output | 2 | Range code of the selected channel |
| convReq | output | 1 | Conversion request pulse |
| convValid | input | 1 | Conversion result is present |
| convData | input | DATA_W | Conversion result |
| hostAddr | input | HOST_AW | Host register address |
| hostRd | input | 1 | Host read strobe |
| hostWr | input | 1 | Host write strobe |
| hostWdata | input | 32 | Host write data |
| hostRdata | output | 32 | Host read data |

## Verification
The hardest case to reach from the ports is the boundary between a result that lands in the final cycle of its slot and one that lands a single cycle later. The bench's converter model has a programmable delay. It is run once with the reply placed on the last slot cycle, where every result must be stored and no overrun counted. It is run again one cycle later, where every slot must count an overrun and the FIFO must stay empty. A long run in which the converter never replies drives the overrun counter to saturation. A long run with the host silent fills the FIFO past its 256 entries.

// File: rtl/chan_scan_pkg.sv
package chan_scan_pkg;
  localparam int NUM_CH  = 16;
  localparam int CH_W    = $clog2(NUM_CH);
  localparam int RANGE_W = 2;
  localparam int OVR_W   = 8;

  typedef enum logic [1:0] {
    ST_LOAD  = 2'd0,
    ST_CHECK = 2'd1,
    ST_EMPTY = 2'd2,
    ST_SCAN  = 2'd3
  } seqState_t;

  // strobes and levels sent from the control path to the datapath
  typedef struct packed {
    logic            cfgWe;
    logic [CH_W-1:0] cfgIdx;
    logic            push;
    logic [CH_W-1:0] pushCh;
    logic            overrun;
    logic            flush;
    logic            cfgEmpty;
    logic            scanning;
    logic            cfgLoaded;
  } seqStrobes_t;
endpackage

// File: rtl/chan_scan_fifo.sv
module chan_scan_fifo #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full
);
  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW:0]      wrPtr, rdPtr;
  logic             doPush, doPop;

  assign empty  = (wrPtr == rdPtr);
  assign full   = (wrPtr[AW] != rdPtr[AW]) && (wrPtr[AW-1:0] == rdPtr[AW-1:0]);
  assign doPush = push && !full && !flush;
  assign doPop  = pop && !empty && !flush;
  assign dout   = mem[rdPtr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr[AW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop)  rdPtr <= rdPtr + 1'b1;
    end
  end

  // R8: a push into a full buffer leaves the write side untouched
  a_r8_drop_when_full: assert property (@(posedge clk) disable iff (!rstN)
    (full && push && !pop && !flush) |=> (full && wrPtr == $past(wrPtr)));

  // R7: popping an empty buffer keeps it empty
  a_r7_empty_pop_noop: assert property (@(posedge clk) disable iff (!rstN)
    (empty && pop && !push && !flush) |=> empty);
endmodule

// File: rtl/chan_scan_ctrl.sv
module chan_scan_ctrl
  import chan_scan_pkg::*;
#(
  parameter int SLOT_CYCLES = 10,
  parameter int CFG_AW      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] enMask,
  input  logic              reloadReq,
  output logic              cfgRdReq,
  output logic [CFG_AW-1:0] cfgRdAddr,
  input  logic              cfgRdValid,
  output logic              convReq,
  input  logic              convValid,
  output logic [CH_W-1:0]   muxSel,
  output seqStrobes_t       strb
);
  localparam int SLOT_W = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOT_CYCLES - 1);
  localparam logic [CH_W-1:0]   CH_LAST   = CH_W'(NUM_CH - 1);

  seqState_t         state;
  logic [CH_W-1:0]   loadIdx;
  logic [CH_W-1:0]   curCh;
  logic [SLOT_W-1:0] slotCnt;
  logic              pending;
  logic              slotStart, slotEnd, validHit;

  // round-robin search for the next enabled channel after cur
  function automatic logic [CH_W-1:0] nextEnabled(input logic [CH_W-1:0] cur,
                                                  input logic [NUM_CH-1:0] mask);
    logic [CH_W-1:0] pick;
    logic            found;
    pick  = cur;
    found = 1'b0;
    for (int k = 1; k <= NUM_CH; k++) begin
      logic [CH_W-1:0] idx;
      idx = CH_W'((int'(cur) + k) % NUM_CH);
      if (!found && mask[idx]) begin
        pick  = idx;
        found = 1'b1;
      end
    end
    return pick;
  endfunction

  assign slotStart = (slotCnt == '0);
  assign slotEnd   = (slotCnt == SLOT_LAST);
  assign validHit  = pending && convValid;

  assign cfgRdReq  = (state == ST_LOAD);
  assign cfgRdAddr = CFG_AW'(loadIdx);
  assign convReq   = (state == ST_SCAN) && slotStart;
  assign muxSel    = (state == ST_SCAN) ? curCh : '0;

  always_comb begin
    strb           = '0;
    strb.cfgWe     = (state == ST_LOAD) && cfgRdValid;
    strb.cfgIdx    = loadIdx;
    strb.push      = (state == ST_SCAN) && validHit;
    strb.pushCh    = curCh;
    strb.overrun   = (state == ST_SCAN) && slotEnd && pending && !convValid;
    strb.flush     = reloadReq;
    strb.cfgEmpty  = (state == ST_EMPTY);
    strb.scanning  = (state == ST_SCAN);
    strb.cfgLoaded = (state != ST_LOAD);
  end

  always_ff @(posedge clk) begin
    if (!rstN || reloadReq) begin
      state   <= ST_LOAD;
      loadIdx <= '0;
      curCh   <= '0;
      slotCnt <= '0;
      pending <= 1'b0;
    end else begin
      unique case (state)
        ST_LOAD: begin
          if (cfgRdValid) begin
            loadIdx <= loadIdx + 1'b1;
            if (loadIdx == CH_LAST) state <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          slotCnt <= '0;
          pending <= 1'b0;
          if (|enMask) begin
            curCh <= nextEnabled(CH_LAST, enMask);
            state <= ST_SCAN;
          end else begin
            state <= ST_EMPTY;
          end
        end
        ST_EMPTY: state <= ST_EMPTY;
        ST_SCAN: begin
          slotCnt <= slotEnd ? '0 : slotCnt + 1'b1;
          if (slotEnd)        pending <= 1'b0;
          else if (validHit)  pending <= 1'b0;
          else if (slotStart) pending <= 1'b1;
          if (slotEnd) curCh <= nextEnabled(curCh, enMask);
        end
        default: state <= ST_LOAD;
      endcase
    end
  end

  // R4: only enabled channels receive a conversion request
  a_r4_enabled_only: assert property (@(posedge clk) disable iff (!rstN)
    convReq |-> enMask[muxSel]);

  // R4: the request is a single-cycle pulse
  a_r4_req_pulse: assert property (@(posedge clk) disable iff (!rstN)
    convReq |=> !convReq);

  // R1: configuration addresses advance by one per accepted byte
  a_r1_addr_steps: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRdReq && cfgRdValid && !reloadReq && cfgRdAddr != CFG_AW'(NUM_CH - 1))
      |=> (cfgRdReq && cfgRdAddr == $past(cfgRdAddr) + 1'b1));
endmodule

// File: rtl/chan_scan_dp.sv
module chan_scan_dp
  import chan_scan_pkg::*;
#(
  parameter int FIFO_DEPTH = 256,
  parameter int DATA_W     = 16,
  parameter int HOST_AW    = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobes_t        strb,
  input  logic [7:0]         cfgRdData,
  input  logic [CH_W-1:0]    muxSel,
  input  logic [DATA_W-1:0]  convData,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic               hostRd,
  input  logic               hostWr,
  input  logic [31:0]        hostWdata,
  output logic [31:0]        hostRdata,
  output logic [NUM_CH-1:0]  enMask,
  output logic [NUM_CH-1:0]  rangeGpio,
  output logic [RANGE_W-1:0] rangeCode,
  output logic               reloadReq
);
  localparam int ENTRY_W = CH_W + DATA_W;
  localparam logic [HOST_AW-1:0] ADDR_STAT = HOST_AW'(0);
  localparam logic [HOST_AW-1:0] ADDR_DATA = HOST_AW'(4);
  localparam logic [HOST_AW-1:0] ADDR_CTRL = HOST_AW'(8);
  localparam logic [31:0]        RELOAD_KEY = 32'd1;
  localparam logic [OVR_W-1:0]   OVR_MAX = '1;

  logic [NUM_CH-1:0]  puMask;
  logic [RANGE_W-1:0] rngMem [NUM_CH];
  logic [OVR_W-1:0]   overrunCnt;
  logic               overflowFlag;
  logic               fifoEmpty, fifoFull, fifoPop;
  logic [ENTRY_W-1:0] fifoOut;
  logic               unusedCfgBits;

  assign unusedCfgBits = ^cfgRdData[7:4];

  // configuration image store
  always_ff @(posedge clk) begin
    if (!rstN) begin
      enMask <= '0;
      puMask <= '0;
      for (int i = 0; i < NUM_CH; i++) rngMem[i] <= '0;
    end else if (strb.cfgWe) begin
      enMask[strb.cfgIdx] <= cfgRdData[0];
      rngMem[strb.cfgIdx] <= cfgRdData[2:1];
      puMask[strb.cfgIdx] <= cfgRdData[3];
    end
  end

  assign rangeGpio = strb.cfgLoaded ? puMask : '0;
  assign rangeCode = strb.scanning ? rngMem[muxSel] : '0;

  // host decode
  assign reloadReq = hostWr && (hostAddr == ADDR_CTRL) && (hostWdata == RELOAD_KEY);
  assign fifoPop   = hostRd && (hostAddr == ADDR_DATA) && !fifoEmpty;

  chan_scan_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(ENTRY_W)) uFifo (
    .clk   (clk),
    .rstN  (rstN),
    .flush (strb.flush),
    .push  (strb.push),
    .pop   (fifoPop),
    .din   ({strb.pushCh, convData}),
    .dout  (fifoOut),
    .empty (fifoEmpty),
    .full  (fifoFull)
  );

  always_ff @(posedge clk) begin
    if (!rstN || strb.flush) begin
      overflowFlag <= 1'b0;
      overrunCnt   <= '0;
    end else begin
      if (strb.push && fifoFull) overflowFlag <= 1'b1;
      if (strb.overrun && overrunCnt != OVR_MAX) overrunCnt <= overrunCnt + 1'b1;
    end
  end

  always_comb begin
    hostRdata = '0;
    if (hostAddr == ADDR_STAT) begin
      hostRdata[0]    = fifoEmpty;
      hostRdata[1]    = fifoFull;
      hostRdata[2]    = overflowFlag;
      hostRdata[3]    = strb.cfgEmpty;
      hostRdata[4]    = strb.scanning;
      hostRdata[15:8] = overrunCnt;
    end else if (hostAddr == ADDR_DATA && !fifoEmpty) begin
      hostRdata = {{(32 - ENTRY_W){1'b0}}, fifoOut};
    end
  end

  // R6: the overrun count holds at its ceiling
  a_r6_overrun_saturates: assert property (@(posedge clk) disable iff (!rstN)
    (overrunCnt == OVR_MAX && !strb.flush) |=> overrunCnt == OVR_MAX);

  // R6: each missed slot below the ceiling adds exactly one
  a_r6_overrun_step: assert property (@(posedge clk) disable iff (!rstN)
    (strb.overrun && overrunCnt != OVR_MAX && !strb.flush)
      |=> overrunCnt == $past(overrunCnt) + 1'b1);

  // R10: a reload leaves an empty buffer and cleared error state
  a_r10_flush_clears: assert property (@(posedge clk) disable iff (!rstN)
    strb.flush |=> (fifoEmpty && !overflowFlag && overrunCnt == '0));

  // R8: the overflow flag only rises on a dropped result
  a_r8_overflow_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflowFlag) |-> $past(strb.push && fifoFull));
endmodule

// File: rtl/chan_scan_seq.sv
module chan_scan_seq
  import chan_scan_pkg::*;
#(
  parameter int SLOT_CYCLES = 10,
  parameter int FIFO_DEPTH  = 256,
  parameter int DATA_W      = 16,
  parameter int CFG_AW      = 8,
  parameter int HOST_AW     = 4
) (
  input  logic               clk,
  input  logic               rstN,
  output logic               cfgRdReq,
  output logic [CFG_AW-1:0]  cfgRdAddr,
  input  logic               cfgRdValid,
  input  logic [7:0]         cfgRdData,
  output logic [NUM_CH-1:0]  rangeGpio,
  output logic [CH_W-1:0]    muxSel,
  output logic [RANGE_W-1:0] rangeCode,
  output logic               convReq,
  input  logic               convValid,
  input  logic [DATA_W-1:0]  convData,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic               hostRd,
  input  logic               hostWr,
  input  logic [31:0]        hostWdata,
  output logic [31:0]        hostRdata
);
  seqStrobes_t       strb;
  logic [NUM_CH-1:0] enMask;
  logic              reloadReq;

  chan_scan_ctrl #(.SLOT_CYCLES(SLOT_CYCLES), .CFG_AW(CFG_AW)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .enMask     (enMask),
    .reloadReq  (reloadReq),
    .cfgRdReq   (cfgRdReq),
    .cfgRdAddr  (cfgRdAddr),
    .cfgRdValid (cfgRdValid),
    .convReq    (convReq),
    .convValid  (convValid),
    .muxSel     (muxSel),
    .strb       (strb)
  );

  chan_scan_dp #(.FIFO_DEPTH(FIFO_DEPTH), .DATA_W(DATA_W), .HOST_AW(HOST_AW)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .cfgRdData (cfgRdData),
    .muxSel    (muxSel),
    .convData  (convData),
    .hostAddr  (hostAddr),
    .hostRd    (hostRd),
    .hostWr    (hostWr),
    .hostWdata (hostWdata),
    .hostRdata (hostRdata),
    .enMask    (enMask),
    .rangeGpio (rangeGpio),
    .rangeCode (rangeCode),
    .reloadReq (reloadReq)
  );
endmodule

// File: tb/chan_scan_seq_test.sv
`timescale 1ns/1ps
module chan_scan_seq_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgRdReq, cfgRdValid;
  logic [7:0]  cfgRdAddr, cfgRdData;
  logic [15:0] rangeGpio;
  logic [3:0]  muxSel;
  logic [1:0]  rangeCode;
  logic        convReq, convValid;
  logic [15:0] convData;
  logic [3:0]  hostAddr;
  logic        hostRd, hostWr;
  logic [31:0] hostWdata, hostRdata;

  always #4 clk = ~clk;

  chan_scan_seq uut (
    .clk(clk), .rstN(rstN), .cfgRdReq(cfgRdReq), .cfgRdAddr(cfgRdAddr),
    .cfgRdValid(cfgRdValid), .cfgRdData(cfgRdData), .rangeGpio(rangeGpio),
    .muxSel(muxSel), .rangeCode(rangeCode), .convReq(convReq),
    .convValid(convValid), .convData(convData), .hostAddr(hostAddr),
    .hostRd(hostRd), .hostWr(hostWr), .hostWdata(hostWdata), .hostRdata(hostRdata)
  );

  // {enable mask, pull-up mask, range codes (2 bits per channel)}
  localparam logic [63:0] VECS [4] = '{
    {16'hFFFF, 16'h0000, 32'h0000_0000},
    {16'h8421, 16'hF0F0, 32'h1B1B_E4E4},
    {16'h0001, 16'hFFFF, 32'hFFFF_FFFF},
    {16'h8000, 16'h0001, 32'h5555_AAAA}
  };

  logic [7:0] image [16];
  logic       modelCheck = 1'b0;
  logic       adcOn = 1'b1;
  int         adcLat = 3;
  int         pokeCnt = 0;
  bit         done = 1'b0;
  int checks = 0, errors = 0;
  int mChecks = 0, mErrors = 0;
  int eChecks = 0, eErrors = 0;

  // configuration memory model: answers two cycles after a request
  initial begin
    int eeCnt = 0;
    int eeExp = 0;
    logic [7:0] eeAddr = '0;
    cfgRdValid = 1'b0;
    cfgRdData  = '0;
    forever begin
      @(negedge clk);
      cfgRdValid = 1'b0;
      if (eeCnt > 0) begin
        eeCnt--;
        if (eeCnt == 0) begin
          cfgRdValid = 1'b1;
          cfgRdData  = image[eeAddr[3:0]];
        end
      end else if (rstN && cfgRdReq) begin
        eeAddr = cfgRdAddr;
        eChecks++;
        if (eeAddr != 8'(eeExp)) begin
          eErrors++;
          $display("FAIL R1: config address got %0d expected %0d", eeAddr, eeExp);
        end
        eeExp = (eeExp + 1) % 16;
        eeCnt = 2;
      end
    end
  end

  // converter model: replies adcLat negedges after the request
  initial begin
    int busy = 0;
    int pokeSeen = 0;
    logic [3:0] reqCh = '0;
    logic [7:0] seq = '0;
    convValid = 1'b0;
    convData  = '0;
    forever begin
      @(negedge clk);
      convValid = 1'b0;
      if (busy > 0) begin
        busy--;
        if (busy == 0) begin
          convValid = 1'b1;
          convData  = {4'h5, reqCh, seq};
          seq++;
        end
      end
      if (pokeCnt != pokeSeen) begin
        pokeSeen  = pokeCnt;
        convValid = 1'b1;
        convData  = 16'hDEAD;
      end
      if (rstN && convReq) begin
        mChecks++;
        if (cfgRdReq) begin
          mErrors++;
          $display("FAIL R1: convReq during load got 1 expected 0");
        end
        if (modelCheck) begin
          mChecks += 2;
          if (rangeCode != image[muxSel][2:1]) begin
            mErrors++;
            $display("FAIL R2: rangeCode ch%0d got %0d expected %0d", muxSel, rangeCode, image[muxSel][2:1]);
          end
          if (!image[muxSel][0]) begin
            mErrors++;
            $display("FAIL R4: request on disabled ch got %0d expected enabled", muxSel);
          end
        end
        if (adcOn) begin
          reqCh = muxSel;
          busy  = adcLat;
        end
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic readReg(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    hostAddr = a;
    hostRd   = 1'b1;
    #1 d = hostRdata;
    @(negedge clk);
    hostRd = 1'b0;
  endtask

  task automatic writeReg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    hostAddr  = a;
    hostWdata = d;
    hostWr    = 1'b1;
    @(negedge clk);
    hostWr    = 1'b0;
    hostWdata = '0;
  endtask

  function automatic logic [3:0] nextEn(input logic [3:0] cur, input logic [15:0] m);
    for (int k = 1; k <= 16; k++) begin
      logic [3:0] idx;
      idx = 4'((int'(cur) + k) % 16);
      if (m[idx]) return idx;
    end
    return cur;
  endfunction

  task automatic setImage(input logic [63:0] v);
    for (int c = 0; c < 16; c++)
      image[c] = {4'hA, v[32 + c], v[2*c +: 2], v[48 + c]};
  endtask

  // wait until status bit b reads as 1
  task automatic waitStatus(input int b, input string req);
    logic [31:0] s;
    int n = 0;
    s = '0;
    while (!s[b] && n < 300) begin
      readReg(4'd0, s);
      n++;
    end
    check(req, 32'(s[b]), 32'd1);
  endtask

  task automatic reloadWith(input logic [63:0] v);
    modelCheck = 1'b0;
    setImage(v);
    writeReg(4'd8, 32'd1);
  endtask

  task automatic checkOrder(input logic [15:0] en, input int n);
    logic [31:0] d, s;
    logic [3:0]  expCh;
    logic [7:0]  prevLow;
    expCh   = nextEn(4'd15, en);
    prevLow = '0;
    for (int i = 0; i < n; i++) begin
      int w = 0;
      s = 32'd1;
      while (s[0] && w < 200) begin
        readReg(4'd0, s);
        w++;
      end
      readReg(4'd4, d);
      check("R4 channel order", 32'(d[19:16]), 32'(expCh));
      check("R5 data tag", 32'(d[11:8]), 32'(d[19:16]));
      if (i > 0) check("R5 no lost result", 32'(d[7:0]), 32'(prevLow + 8'd1));
      prevLow = d[7:0];
      expCh   = nextEn(expCh, en);
    end
  endtask

  initial begin
    logic [31:0] s, d;
    hostAddr = '0; hostRd = 1'b0; hostWr = 1'b0; hostWdata = '0;
    setImage(VECS[0]);
    repeat (4) @(negedge clk);
    // reset state
    check("R1 reset req", 32'(cfgRdReq), 32'd1);
    check("R1 reset addr", 32'(cfgRdAddr), 32'd0);
    check("R3 reset gpio", 32'(rangeGpio), 32'd0);
    check("R4 reset convReq", 32'(convReq), 32'd0);
    hostAddr = 4'd0;
    #1 check("R7 reset status", hostRdata, 32'h0000_0001);
    @(negedge clk);
    rstN = 1'b1;
    waitStatus(4, "R4 scanning after load");
    modelCheck = 1'b1;

    // table of configurations walked by one loop
    for (int v = 0; v < 4; v++) begin
      reloadWith(VECS[v]);
      check("R1 reload starts load", 32'(cfgRdReq), 32'd1);
      check("R3 gpio low while loading", 32'(rangeGpio), 32'd0);
      waitStatus(4, "R4 scanning");
      modelCheck = 1'b1;
      check("R3 pull-up lines", 32'(rangeGpio), 32'(VECS[v][47:32]));
      checkOrder(VECS[v][63:48], 10);
    end

    // no channel enabled
    reloadWith(64'h0000_FFFF_FFFF_FFFF);
    waitStatus(3, "R9 config empty flag");
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (convReq) check("R9 no request", 32'(convReq), 32'd0);
    end
    pokeCnt++;
    repeat (3) @(negedge clk);
    readReg(4'd0, s);
    check("R9 status idle", s, 32'h0000_0009);
    readReg(4'd4, d);
    check("R7 empty read returns 0", d, 32'd0);
    check("R5 stray valid ignored", 32'(muxSel), 32'd0);
    readReg(4'd0, s);
    check("R7 empty read no effect", s, 32'h0000_0009);

    // result in the last slot cycle is kept
    adcLat = 9;
    reloadWith(VECS[1]);
    waitStatus(4, "R4 scanning");
    modelCheck = 1'b1;
    repeat (200) @(negedge clk);
    readReg(4'd0, s);
    check("R5 last-cycle result no overrun", 32'(s[15:8]), 32'd0);
    check("R5 last-cycle result stored", 32'(s[0]), 32'd0);

    // result one cycle late is an overrun and is dropped
    adcLat = 10;
    reloadWith(VECS[1]);
    waitStatus(4, "R4 scanning");
    modelCheck = 1'b1;
    repeat (200) @(negedge clk);
    readReg(4'd0, s);
    check("R6 late result dropped", 32'(s[0]), 32'd1);
    check("R6 overruns counted", 32'(s[15:8] >= 8'd15), 32'd1);

    // converter silent: counter saturates
    adcLat = 3;
    adcOn  = 1'b0;
    reloadWith(VECS[0]);
    waitStatus(4, "R4 scanning");
    modelCheck = 1'b1;
    repeat (3000) @(negedge clk);
    readReg(4'd0, s);
    check("R6 overrun saturates", 32'(s[15:8]), 32'd255);

    // host silent: buffer fills and overflows
    adcOn = 1'b1;
    reloadWith(VECS[2]);
    readReg(4'd0, s);
    check("R10 flush clears", s & 32'h0000_FF07, 32'h0000_0001);
    waitStatus(4, "R4 scanning");
    modelCheck = 1'b1;
    repeat (2800) @(negedge clk);
    readReg(4'd0, s);
    check("R8 full flag", 32'(s[1]), 32'd1);
    check("R8 overflow flag", 32'(s[2]), 32'd1);
    readReg(4'd4, d);
    check("R7 oldest entry channel", 32'(d[19:16]), 32'd0);
    readReg(4'd0, s);
    check("R8 not full after pop", 32'(s[1]), 32'd0);
    check("R8 overflow sticky", 32'(s[2]), 32'd1);
    reloadWith(VECS[2]);
    readReg(4'd0, s);
    check("R10 overflow cleared", s & 32'h0000_FF07, 32'h0000_0001);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks",
             errors + mErrors + eErrors, checks + mChecks + eChecks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks",
               errors + mErrors + eErrors + 1, checks + mChecks + eChecks + 1);
      $finish;
    end
  end
endmodule